// File: doc/BRIEF.md
# UART Modem Control and Line Status Registers

This block holds the modem output controls and the line status word of a 16550-style serial port. Software reaches it through a small word-addressed register interface. The block does not contain the receiver, the transmitter shift logic, the FIFOs or the baud generator. Their activity arrives as single-cycle event strobes, a bit-period tick and empty indications.

The control word drives the four active-low modem output pins. It also has a loopback switch. In loopback the serial output idles high and the modem output pins go to their inactive high level. The four control bits are then wired internally to the four modem status bits.

The status word collects several conditions:
- overrun, parity and framing strobes from the receiver;
- a break condition, found by watching the serial input across baud ticks;
- the transmitter empty levels;
- a count of error-carrying bytes held in the receive FIFO.

The error flags hold until software reads the status word.

Top module: `uart_mcls`

## Requirements
- R1: Register 0 (control) is read/write with bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2 and bit 4 LOOP. Bits above 4 are dropped on write and read as zero. The register resets to 0.
- R2: With LOOP clear, each of dtr_n, rts_n, out1_n and out2_n is the inverse of its control bit. A 1 in the bit drives the pin low. sout follows tx_sout.
- R3: With LOOP set, sout is 1 and dtr_n, rts_n, out1_n and out2_n are all 1, whatever the other control bits and tx_sout are.
- R4: Register 2 (modem status) reads CTS at bit 0, DSR at bit 1, RI at bit 2 and DCD at bit 3; higher bits read zero. With LOOP clear each bit is the inverse of its pin (cts_n, dsr_n, ri_n, dcd_n). With LOOP set, CTS takes RTS, DSR takes DTR, RI takes OUT1 and DCD takes OUT2.
- R5: Register 1 (line status) resets to 0x60. Bit 5 equals thr_empty. Bit 6 equals thr_empty AND tsr_empty. Both bits reflect the inputs from the cycle after they are applied. Bit 0 and bits above 7 read zero.
- R6: A pulse on oe_evt, pe_evt or fe_evt sets bit 1, bit 2 or bit 3 of the line status. The bit holds until the line status register is read, and it reads clear from the next access on.
- R7: An error event that arrives in the same cycle as a line status read leaves its flag set after the read.
- R8: Line status bit 4 (break) sets when sin has been low across FRAME_BITS+1 bit ticks in a row. It sets once per low period, clears on read, and re-arms only after sin returns high.
- R9: Line status bit 7 is 1 when fifo_mode is 1 and the count of errored bytes in the receive FIFO is nonzero. The count rises on err_push, falls on err_pop, and saturates at 0 and FIFO_DEPTH. A status read does not clear it.
- R10: Writes to registers 1, 2 and 3 change no state. A read of register 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears line status errors) |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| tx_sout | input | 1 | Serial data from the transmitter |
| sout | output | 1 | Serial output pin |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| sin | input | 1 | Serial input, already synchronous to clk |
| bit_tick | input | 1 | One pulse per serial bit period |
| oe_evt | input | 1 | Overrun event strobe |
| pe_evt | input | 1 | Parity error event strobe |
| fe_evt | input | 1 | Framing error event strobe |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| fifo_mode | input | 1 | FIFO mode enable |
| err_push | input | 1 | An errored byte entered the receive FIFO |
| err_pop | input | 1 | An errored byte left the receive FIFO |

## Verification
The bench builds the block with FRAME_BITS=4 and FIFO_DEPTH=4. With FRAME_BITS=4 the break threshold of five ticks is short, so the bench can test the ticks just below and at the threshold, and the re-arm after the line goes high, in a few cycles. With FIFO_DEPTH=4 the errored-byte counter can be driven to both saturation limits. The small register width lets the bench sweep all 32 control values against all 16 modem pin patterns, every transmitter-empty combination and every mix of the three error strobes.

// File: rtl/uart_mcls_pkg.sv
package uart_mcls_pkg;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mcr_t;

    localparam int unsigned CTL_BITS  = 5;
    localparam int unsigned LSR_BITS  = 8;
    localparam int unsigned MSR_BITS  = 4;
    localparam int unsigned NUM_MODEM = 4;

    localparam int unsigned REG_CTL = 0;
    localparam int unsigned REG_LSR = 1;
    localparam int unsigned REG_MSR = 2;
    localparam int unsigned NUM_REG = 3;

    // status bit k is fed in loopback from control bit LB_SRC[k]
    // (control bits: 0 dtr, 1 rts, 2 out1, 3 out2; status: 0 cts, 1 dsr, 2 ri, 3 dcd)
    localparam int unsigned LB_SRC [0:3] = '{1, 0, 2, 3};

endpackage

// File: rtl/mcls_modem_ctl.sv
module mcls_modem_ctl
    import uart_mcls_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  mcr_t                 wr_val,
    input  logic                 tx_sout,
    input  logic [NUM_MODEM-1:0] stat_pin_n,
    output mcr_t                 ctl,
    output logic                 sout,
    output logic [NUM_MODEM-1:0] ctl_pin_n,
    output logic [MSR_BITS-1:0]  msr
);

    typedef struct packed {
        mcr_t ctl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctl = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [NUM_MODEM-1:0] ctl_bits;
    assign ctl_bits = {st_q.ctl.out2, st_q.ctl.out1, st_q.ctl.rts, st_q.ctl.dtr};
    assign ctl      = st_q.ctl;
    assign sout     = st_q.ctl.loop ? 1'b1 : tx_sout;

    for (genvar k = 0; k < NUM_MODEM; k++) begin : g_modem
        assign ctl_pin_n[k] = st_q.ctl.loop ? 1'b1 : ~ctl_bits[k];
        assign msr[k]       = st_q.ctl.loop ? ctl_bits[LB_SRC[k]] : ~stat_pin_n[k];
    end

    p_dtr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_val.loop && wr_val.dtr) |=> !ctl_pin_n[0]);

    p_loop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val.loop) |=> (sout && (ctl_pin_n == '1)));

    p_loop_cts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val.loop && wr_val.rts) |=> msr[0]);

endmodule

// File: rtl/mcls_brk_det.sv
module mcls_brk_det #(
    parameter int unsigned FRAME_BITS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sin,
    input  logic bit_tick,
    output logic brk_evt
);

    localparam int unsigned CW = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        brk_evt = 1'b0;
        if (sin) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (bit_tick && st_q.armed) begin
            if (st_q.cnt == CW'(FRAME_BITS)) begin
                brk_evt    = 1'b1;
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(FRAME_BITS));

    p_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !sin) |=> !st_q.armed);

endmodule

// File: rtl/mcls_line_stat.sv
module mcls_line_stat
    import uart_mcls_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                oe_evt,
    input  logic                pe_evt,
    input  logic                fe_evt,
    input  logic                brk_evt,
    input  logic                thr_empty,
    input  logic                tsr_empty,
    input  logic                fifo_mode,
    input  logic                err_push,
    input  logic                err_pop,
    output logic [LSR_BITS-1:0] lsr
);

    localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic          oe;
        logic          pe;
        logic          fe;
        logic          bi;
        logic          thre;
        logic          temt;
        logic [CW-1:0] ecnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.thre = thr_empty;
        st_d.temt = thr_empty & tsr_empty;
        if (clr) begin
            st_d.oe = 1'b0;
            st_d.pe = 1'b0;
            st_d.fe = 1'b0;
            st_d.bi = 1'b0;
        end
        if (oe_evt)  st_d.oe = 1'b1;
        if (pe_evt)  st_d.pe = 1'b1;
        if (fe_evt)  st_d.fe = 1'b1;
        if (brk_evt) st_d.bi = 1'b1;
        if (err_push && !err_pop && st_q.ecnt != CW'(FIFO_DEPTH)) begin
            st_d.ecnt = st_q.ecnt + 1'b1;
        end else if (err_pop && !err_push && st_q.ecnt != '0) begin
            st_d.ecnt = st_q.ecnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{oe: 1'b0, pe: 1'b0, fe: 1'b0, bi: 1'b0,
                      thre: 1'b1, temt: 1'b1, ecnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lsr = {fifo_mode && (st_q.ecnt != '0), st_q.temt, st_q.thre,
                  st_q.bi, st_q.fe, st_q.pe, st_q.oe, 1'b0};

    p_temt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.temt |-> st_q.thre);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fe && !clr) |=> st_q.fe);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !oe_evt) |=> !st_q.oe);

    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && pe_evt) |=> st_q.pe);

    p_fifo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> !lsr[7]);

    p_ecnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_push && !err_pop) |=> (st_q.ecnt != '0));

endmodule

// File: rtl/uart_mcls.sv
module uart_mcls
    import uart_mcls_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned FRAME_BITS = 12,
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_sout,
    output logic              sout,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    input  logic              sin,
    input  logic              bit_tick,
    input  logic              oe_evt,
    input  logic              pe_evt,
    input  logic              fe_evt,
    input  logic              thr_empty,
    input  logic              tsr_empty,
    input  logic              fifo_mode,
    input  logic              err_push,
    input  logic              err_pop
);

    logic                 sel_ctl, sel_lsr, sel_msr;
    logic                 ctl_wr, lsr_rd;
    mcr_t                 ctl, wr_val;
    logic [NUM_MODEM-1:0] pin_n;
    logic [MSR_BITS-1:0]  msr;
    logic [LSR_BITS-1:0]  lsr;
    logic                 brk_evt;

    always_comb begin
        sel_ctl = (bus_addr == ADDR_W'(REG_CTL));
        sel_lsr = (bus_addr == ADDR_W'(REG_LSR));
        sel_msr = (bus_addr == ADDR_W'(REG_MSR));
        ctl_wr  = bus_wr && sel_ctl;
        lsr_rd  = bus_rd && sel_lsr;
        wr_val  = mcr_t'(bus_wdata[CTL_BITS-1:0]);
    end

    mcls_modem_ctl u_modem (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_wr),
        .wr_val     (wr_val),
        .tx_sout    (tx_sout),
        .stat_pin_n ({dcd_n, ri_n, dsr_n, cts_n}),
        .ctl        (ctl),
        .sout       (sout),
        .ctl_pin_n  (pin_n),
        .msr        (msr)
    );

    assign dtr_n  = pin_n[0];
    assign rts_n  = pin_n[1];
    assign out1_n = pin_n[2];
    assign out2_n = pin_n[3];

    mcls_brk_det #(.FRAME_BITS(FRAME_BITS)) u_brk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sin      (sin),
        .bit_tick (bit_tick),
        .brk_evt  (brk_evt)
    );

    mcls_line_stat #(.FIFO_DEPTH(FIFO_DEPTH)) u_lsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (lsr_rd),
        .oe_evt    (oe_evt),
        .pe_evt    (pe_evt),
        .fe_evt    (fe_evt),
        .brk_evt   (brk_evt),
        .thr_empty (thr_empty),
        .tsr_empty (tsr_empty),
        .fifo_mode (fifo_mode),
        .err_push  (err_push),
        .err_pop   (err_pop),
        .lsr       (lsr)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_ctl) begin
            bus_rdata[CTL_BITS-1:0] = ctl;
        end else if (sel_lsr) begin
            bus_rdata[LSR_BITS-1:0] = lsr;
        end else if (sel_msr) begin
            bus_rdata[MSR_BITS-1:0] = msr;
        end
    end

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_ctl) |-> (bus_rdata[DATA_W-1:CTL_BITS] == '0));

    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !sel_ctl && !sel_lsr && !sel_msr) |-> (bus_rdata == '0));

    p_lsr_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sel_ctl) |=> $stable(ctl));

endmodule

// File: tb/sim_uart_mcls.sv
module sim_uart_mcls;

    localparam int DW = 16;
    localparam int AW = 2;
    localparam int FB = 4;
    localparam int FD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 0, bus_rd = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic tx_sout = 0, sout, dtr_n, rts_n, out1_n, out2_n;
    logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
    logic sin = 1, bit_tick = 0, oe_evt = 0, pe_evt = 0, fe_evt = 0;
    logic thr_empty = 1, tsr_empty = 1, fifo_mode = 1, err_push = 0, err_pop = 0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_mcls #(.DATA_W(DW), .ADDR_W(AW), .FRAME_BITS(FB), .FIFO_DEPTH(FD)) u0 (.*);

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        bus_rd = 1; bus_addr = AW'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic tick();
        bit_tick = 1;
        @(negedge clk);
        bit_tick = 0;
    endtask

    logic [DW-1:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        rd(0, v); chk("R1 reset ctl", v, 16'h0000);
        rd(1, v); chk("R5 reset lsr", v, 16'h0060);
        rd(2, v); chk("R4 reset msr", v, 16'h0000);
        chk("R2 reset pins", {12'h0, out2_n, out1_n, rts_n, dtr_n}, 16'h000F);

        // control sweep against every pin pattern
        for (int c = 0; c < 32; c++) begin
            tx_sout = c[0] ^ c[2];
            wr(0, 16'hFFE0 | DW'(c));
            rd(0, v); chk("R1 ctl readback", v, DW'(c));
            if (c[4]) begin
                chk("R3 loop pins", {11'h0, sout, out2_n, out1_n, rts_n, dtr_n}, 16'h001F);
            end else begin
                chk("R2 pins", {11'h0, sout, out2_n, out1_n, rts_n, dtr_n},
                    {11'h0, tx_sout, ~c[3], ~c[2], ~c[1], ~c[0]});
            end
            for (int p = 0; p < 16; p++) begin
                {dcd_n, ri_n, dsr_n, cts_n} = 4'(p);
                rd(2, v);
                if (c[4]) chk("R4 loop msr", v, {12'h0, c[3], c[2], c[0], c[1]});
                else      chk("R4 msr", v, {12'h0, ~4'(p)});
            end
        end
        {dcd_n, ri_n, dsr_n, cts_n} = 4'hF;
        wr(0, 16'h0000);

        // R10 writes elsewhere ignored, unmapped read zero
        wr(0, 16'h000A);
        wr(1, 16'hFFFF); wr(2, 16'hFFFF); wr(3, 16'hFFFF);
        rd(0, v); chk("R10 ctl unchanged", v, 16'h000A);
        rd(1, v); chk("R10 lsr unchanged", v, 16'h0060);
        rd(3, v); chk("R10 unmapped", v, 16'h0000);
        wr(0, 16'h0000);

        // R5 empty combinations
        for (int t = 0; t < 4; t++) begin
            thr_empty = t[0]; tsr_empty = t[1];
            @(negedge clk);
            rd(1, v);
            chk("R5 empty bits", v, {9'h0, t[0] & t[1], t[0], 5'h0});
        end
        thr_empty = 1; tsr_empty = 1;
        @(negedge clk);

        // R6 error mixes, sticky and clear on read
        for (int e = 1; e < 8; e++) begin
            oe_evt = e[0]; pe_evt = e[1]; fe_evt = e[2];
            @(negedge clk);
            oe_evt = 0; pe_evt = 0; fe_evt = 0;
            repeat (2) @(negedge clk);
            rd(1, v); chk("R6 flags set", v, 16'h0060 | DW'(e << 1));
            rd(1, v); chk("R6 flags cleared", v, 16'h0060);
        end

        // R7 event in same cycle as read
        pe_evt = 1; oe_evt = 1;
        rd(1, v); chk("R7 prior value", v, 16'h0060);
        pe_evt = 0; oe_evt = 0;
        rd(1, v); chk("R7 kept", v, 16'h0066);
        rd(1, v); chk("R7 then clear", v, 16'h0060);

        // R8 break detection
        sin = 0;
        for (int i = 0; i < FB; i++) tick();
        rd(1, v); chk("R8 below threshold", v, 16'h0060);
        tick();
        rd(1, v); chk("R8 break set", v, 16'h0070);
        repeat (FB + 3) tick();
        rd(1, v); chk("R8 once per low period", v, 16'h0060);
        sin = 1; tick(); sin = 0;
        for (int i = 0; i <= FB; i++) tick();
        rd(1, v); chk("R8 re-armed", v, 16'h0070);
        sin = 1;
        rd(1, v); chk("R8 cleared", v, 16'h0060);
        sin = 0; tick(); tick(); sin = 1; tick(); sin = 0;
        for (int i = 0; i < FB; i++) tick();
        rd(1, v); chk("R8 count restarts", v, 16'h0060);
        sin = 1;

        // R9 errored-byte count
        err_push = 1;
        for (int i = 0; i < FD + 2; i++) @(negedge clk);
        err_push = 0;
        rd(1, v); chk("R9 fifo err", v, 16'h00E0);
        rd(1, v); chk("R9 not cleared by read", v, 16'h00E0);
        fifo_mode = 0;
        rd(1, v); chk("R9 fifo mode off", v, 16'h0060);
        fifo_mode = 1;
        err_pop = 1;
        for (int i = 0; i < FD - 1; i++) @(negedge clk);
        err_pop = 0;
        rd(1, v); chk("R9 one left", v, 16'h00E0);
        err_pop = 1; @(negedge clk); @(negedge clk); err_pop = 0;
        rd(1, v); chk("R9 empty", v, 16'h0060);
        err_push = 1; err_pop = 1; @(negedge clk); err_push = 0; err_pop = 0;
        rd(1, v); chk("R9 push and pop", v, 16'h0060);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule